// File: doc/BRIEF.md
# Host I/O Port Bank for a Serial Link Adapter

This block sits on the host's byte-wide I/O bus and gives software a handful of ports. Through them software exchanges bytes with a serial-link channel and drives the control lines of a processor network. On the link side, one byte flows in and one byte flows out, each through a valid/ready handshake. Each direction has a status port. Bit 0 of a status port is a flag that software polls, and bit 1 enables the interrupt for that direction. A single interrupt request combines both directions.

The network side has three lines. The reset and analyse outputs are active-low and are set through two write-only ports. The error flag is read back from the same address that takes reset writes. The error inputs are active-low, any one of them raises the flag, and they pass through a two-flop synchronizer before the flag can be read.

Top module: `hostio_bridge`

## Requirements
- R1: All ports are at offsets from the parameter BASE (default 0x300). Reads are decoded at +0x00 (input data), +0x02 (input status), +0x03 (output status) and +0x10 (error). Writes are decoded at +0x01 (output data), +0x02, +0x03, +0x10 (reset) and +0x11 (analyse). Every other address reads 0x00, and a write to it has no effect.
- R2: `lk_in_ready` is 1 exactly when no input byte is held, so a link byte is taken only into an empty holder. A host read of +0x00 returns the held byte and clears the held flag at that clock edge.
- R3: A host write to +0x01 while the output flag is 1 stores the byte, drives `lk_out_valid`=1 with that byte on `lk_out_data`, and clears the flag. A write while the flag is 0 is ignored. The flag returns to 1 at the edge where `lk_out_valid` and `lk_out_ready` are both 1, and the byte stays stable until then.
- R4: A status port reads {6'b0, enable, flag}. The flag is "input byte held" at +0x02 and "output can accept" at +0x03. A write sets the enable from bit 1 and leaves the flag unchanged.
- R5: `irq` = (input held AND input enable) OR (output can accept AND output enable).
- R6: The error port +0x10 reads 0x01 when any bit of `err_n` is 0, and 0x00 otherwise. A change at the input becomes readable after the second rising clock edge.
- R7: Writing +0x10 drives `net_reset_n` to the inverse of bit 0 of the written byte, and writing +0x11 does the same for `net_analyse_n`. Reading +0x10 never returns the reset setting.
- R8: After reset, both enables are 0, no input byte is held, the output flag is 1, `irq`=0, and `net_reset_n` = `net_analyse_n` = 1.
- R9: A write to input data (+0x00) changes nothing. Reads of output data (+0x01) and analyse (+0x11) return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wr | input | 1 | Single-cycle write strobe |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte (combinational, 0 when not reading) |
| irq | output | 1 | Combined interrupt request |
| lk_in_valid | input | 1 | Link byte offered to host |
| lk_in_data | input | 8 | Link byte to host |
| lk_in_ready | output | 1 | Input holder empty |
| lk_out_valid | output | 1 | Host byte offered to link |
| lk_out_data | output | 8 | Host byte to link |
| lk_out_ready | input | 1 | Link takes the byte |
| err_n | input | NPROC | Active-low error lines, asynchronous |
| net_reset_n | output | 1 | Active-low network reset |
| net_analyse_n | output | 1 | Active-low network analyse |

## Verification
The assertions assume the host drives at most one of `io_rd` and `io_wr` in a cycle, and each strobe for one cycle with a stable address. They also assume the link sources keep their valid/ready lines at known values after reset. The bench drives every strobe and handshake line from the falling edge, raises at most one strobe per transfer, and holds every link line at a defined level for the whole run. It changes `err_n` only between transfers, so the synchronizer delay can be counted in whole cycles.

// File: rtl/hostio_pkg.sv
package hostio_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OFF_IN_DATA  = 8'h00;
  localparam logic [7:0] OFF_OUT_DATA = 8'h01;
  localparam logic [7:0] OFF_IN_STAT  = 8'h02;
  localparam logic [7:0] OFF_OUT_STAT = 8'h03;
  localparam logic [7:0] OFF_ERR_RST  = 8'h10;
  localparam logic [7:0] OFF_ANALYSE  = 8'h11;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_IN_DATA,
    RSEL_IN_STAT,
    RSEL_OUT_STAT,
    RSEL_ERR
  } rsel_e;

  // status byte layout: enable in bit 1, flag in bit 0
  function automatic logic [BYTE_W-1:0] stat_byte(input logic ie, input logic flag);
    return {6'b0, ie, flag};
  endfunction

  function automatic logic [BYTE_W-1:0] flag_byte(input logic f);
    return {7'b0, f};
  endfunction
endpackage

// File: rtl/hostio_decode.sv
module hostio_decode
  import hostio_pkg::*;
#(
  parameter int                ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE   = 10'h300
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              rd_in_data,
  output logic              wr_out_data,
  output logic              wr_in_stat,
  output logic              wr_out_stat,
  output logic              wr_rst,
  output logic              wr_ana,
  output rsel_e             rsel
);
  function automatic logic at_port(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == (BASE + ADDR_W'(off));
  endfunction

  logic h_in_data, h_out_data, h_in_stat, h_out_stat, h_err_rst, h_ana;

  assign h_in_data  = at_port(io_addr, OFF_IN_DATA);
  assign h_out_data = at_port(io_addr, OFF_OUT_DATA);
  assign h_in_stat  = at_port(io_addr, OFF_IN_STAT);
  assign h_out_stat = at_port(io_addr, OFF_OUT_STAT);
  assign h_err_rst  = at_port(io_addr, OFF_ERR_RST);
  assign h_ana      = at_port(io_addr, OFF_ANALYSE);

  assign rd_in_data  = io_rd & h_in_data;
  assign wr_out_data = io_wr & h_out_data;
  assign wr_in_stat  = io_wr & h_in_stat;
  assign wr_out_stat = io_wr & h_out_stat;
  assign wr_rst      = io_wr & h_err_rst;
  assign wr_ana      = io_wr & h_ana;

  always_comb begin
    rsel = RSEL_NONE;
    if (h_in_data)       rsel = RSEL_IN_DATA;
    else if (h_in_stat)  rsel = RSEL_IN_STAT;
    else if (h_out_stat) rsel = RSEL_OUT_STAT;
    else if (h_err_rst)  rsel = RSEL_ERR;
  end
endmodule

// File: rtl/hostio_rx_chan.sv
module hostio_rx_chan
  import hostio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [BYTE_W-1:0] lk_data,
  output logic              lk_ready,
  input  logic              host_take,
  output logic              full,
  output logic [BYTE_W-1:0] held
);
  assign lk_ready = ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (full) begin
      if (host_take) full <= 1'b0;
    end else if (lk_valid) begin
      full <= 1'b1;
      held <= lk_data;
    end
  end
endmodule

// File: rtl/hostio_tx_chan.sv
module hostio_tx_chan
  import hostio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_load,
  input  logic [BYTE_W-1:0] host_data,
  output logic              room,
  output logic              lk_valid,
  output logic [BYTE_W-1:0] lk_data,
  input  logic              lk_ready
);
  assign lk_valid = ~room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      room    <= 1'b1;
      lk_data <= '0;
    end else if (room) begin
      if (host_load) begin
        room    <= 1'b0;
        lk_data <= host_data;
      end
    end else if (lk_ready) begin
      room <= 1'b1;
    end
  end
endmodule

// File: rtl/hostio_sync.sv
module hostio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hostio_bridge.sv
module hostio_bridge
  import hostio_pkg::*;
#(
  parameter int                ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE   = 10'h300,
  parameter int                NPROC  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  output logic              irq,
  input  logic              lk_in_valid,
  input  logic [BYTE_W-1:0] lk_in_data,
  output logic              lk_in_ready,
  output logic              lk_out_valid,
  output logic [BYTE_W-1:0] lk_out_data,
  input  logic              lk_out_ready,
  input  logic [NPROC-1:0]  err_n,
  output logic              net_reset_n,
  output logic              net_analyse_n
);
  // decoded events, named for the checker
  logic  rd_in_data, wr_out_data, wr_in_stat, wr_out_stat, wr_rst, wr_ana;
  rsel_e rsel;

  logic              in_full, out_room, err_flag, err_any;
  logic [BYTE_W-1:0] in_byte;
  logic              in_ie, out_ie, rst_req, ana_req;
  logic [BYTE_W-1:0] rd_mux;

  hostio_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .rd_in_data (rd_in_data),
    .wr_out_data(wr_out_data),
    .wr_in_stat (wr_in_stat),
    .wr_out_stat(wr_out_stat),
    .wr_rst     (wr_rst),
    .wr_ana     (wr_ana),
    .rsel       (rsel)
  );

  hostio_rx_chan u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_in_valid),
    .lk_data  (lk_in_data),
    .lk_ready (lk_in_ready),
    .host_take(rd_in_data),
    .full     (in_full),
    .held     (in_byte)
  );

  hostio_tx_chan u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_load(wr_out_data),
    .host_data(io_wdata),
    .room     (out_room),
    .lk_valid (lk_out_valid),
    .lk_data  (lk_out_data),
    .lk_ready (lk_out_ready)
  );

  assign err_any = ~(&err_n);

  hostio_sync #(.STAGES(2)) u_err_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (err_any),
    .q    (err_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ie   <= 1'b0;
      out_ie  <= 1'b0;
      rst_req <= 1'b0;
      ana_req <= 1'b0;
    end else begin
      if (wr_in_stat)  in_ie   <= io_wdata[1];
      if (wr_out_stat) out_ie  <= io_wdata[1];
      if (wr_rst)      rst_req <= io_wdata[0];
      if (wr_ana)      ana_req <= io_wdata[0];
    end
  end

  always_comb begin
    unique case (rsel)
      RSEL_IN_DATA:  rd_mux = in_byte;
      RSEL_IN_STAT:  rd_mux = stat_byte(in_ie, in_full);
      RSEL_OUT_STAT: rd_mux = stat_byte(out_ie, out_room);
      RSEL_ERR:      rd_mux = flag_byte(err_flag);
      default:       rd_mux = '0;
    endcase
  end

  assign io_rdata      = io_rd ? rd_mux : '0;
  assign irq           = (in_full & in_ie) | (out_room & out_ie);
  assign net_reset_n   = ~rst_req;
  assign net_analyse_n = ~ana_req;
endmodule

// File: rtl/hostio_bridge_chk.sv
module hostio_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_wr,
  input logic [7:0] io_wdata,
  input logic       rd_in_data,
  input logic       wr_rst,
  input logic       wr_ana,
  input logic       in_full,
  input logic [7:0] in_byte,
  input logic       lk_in_ready,
  input logic       lk_out_valid,
  input logic       lk_out_ready,
  input logic [7:0] lk_out_data,
  input logic       in_ie,
  input logic       out_ie,
  input logic       irq,
  input logic       net_reset_n,
  input logic       net_analyse_n
);
  p_hold_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_full && !rd_in_data |=> in_full && $stable(in_byte));

  p_no_accept_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_full |-> !lk_in_ready);

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_out_valid && !lk_out_ready |=> lk_out_valid && $stable(lk_out_data));

  p_out_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_out_valid && lk_out_ready && !io_wr |=> !lk_out_valid);

  p_irq_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (in_ie || out_ie));

  p_reset_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> net_reset_n == !$past(io_wdata[0]));

  p_analyse_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ana |=> net_analyse_n == !$past(io_wdata[0]));
endmodule

bind hostio_bridge hostio_bridge_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_wr        (io_wr),
  .io_wdata     (io_wdata),
  .rd_in_data   (rd_in_data),
  .wr_rst       (wr_rst),
  .wr_ana       (wr_ana),
  .in_full      (in_full),
  .in_byte      (in_byte),
  .lk_in_ready  (lk_in_ready),
  .lk_out_valid (lk_out_valid),
  .lk_out_ready (lk_out_ready),
  .lk_out_data  (lk_out_data),
  .in_ie        (in_ie),
  .out_ie       (out_ie),
  .irq          (irq),
  .net_reset_n  (net_reset_n),
  .net_analyse_n(net_analyse_n)
);

// File: tb/test_hostio_bridge.sv
`timescale 1ns/1ps
module test_hostio_bridge;
  localparam int         ADDR_W = 10;
  localparam logic [9:0] BASE   = 10'h300;
  localparam int         NPROC  = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [9:0]       io_addr = '0;
  logic             io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]       io_wdata = '0;
  logic [7:0]       io_rdata;
  logic             irq;
  logic             lk_in_valid = 1'b0;
  logic [7:0]       lk_in_data = '0;
  logic             lk_in_ready;
  logic             lk_out_valid;
  logic [7:0]       lk_out_data;
  logic             lk_out_ready = 1'b0;
  logic [NPROC-1:0] err_n = '1;
  logic             net_reset_n, net_analyse_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  hostio_bridge #(.ADDR_W(ADDR_W), .BASE(BASE), .NPROC(NPROC)) i_hostio_bridge (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq(irq),
    .lk_in_valid(lk_in_valid), .lk_in_data(lk_in_data), .lk_in_ready(lk_in_ready),
    .lk_out_valid(lk_out_valid), .lk_out_data(lk_out_data), .lk_out_ready(lk_out_ready),
    .err_n(err_n), .net_reset_n(net_reset_n), .net_analyse_n(net_analyse_n)
  );

  // vector: [25:24] op (0 write, 1 read-and-compare), [23:16] offset, [15:8] write byte, [7:0] expected
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'h02, 8'hFF, 8'h00}, {2'd1, 8'h02, 8'h00, 8'h02},
    {2'd0, 8'h03, 8'hFE, 8'h00}, {2'd1, 8'h03, 8'h00, 8'h03},
    {2'd0, 8'h03, 8'h00, 8'h00}, {2'd1, 8'h03, 8'h00, 8'h01},
    {2'd0, 8'h02, 8'h00, 8'h00}, {2'd1, 8'h02, 8'h00, 8'h00},
    {2'd1, 8'h01, 8'h00, 8'h00}, {2'd1, 8'h11, 8'h00, 8'h00},
    {2'd0, 8'h10, 8'h01, 8'h00}, {2'd1, 8'h10, 8'h00, 8'h00},
    {2'd1, 8'h04, 8'h00, 8'h00}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    io_addr = BASE + 10'(off); io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] off, output logic [7:0] d);
    @(negedge clk);
    io_addr = BASE + 10'(off); io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check({7'b0, net_reset_n}, 8'h01, "R8 reset_n");
    check({7'b0, net_analyse_n}, 8'h01, "R8 analyse_n");
    check({7'b0, irq}, 8'h00, "R8 irq");
    check({7'b0, lk_in_ready}, 8'h01, "R8 in_ready");
    check({7'b0, lk_out_valid}, 8'h00, "R8 out_valid");
    io_read(8'h02, rv); check(rv, 8'h00, "R8 in status");
    io_read(8'h03, rv); check(rv, 8'h01, "R8 out status");

    // table walk: R1 R4 R7 R9 register behaviour
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][25:24] == 2'd0) io_write(VEC[i][23:16], VEC[i][15:8]);
      else begin
        io_read(VEC[i][23:16], rv);
        check(rv, VEC[i][7:0], $sformatf("R1/R4/R9 vector %0d", i));
      end
    end
    check({7'b0, net_reset_n}, 8'h00, "R7 reset asserted");
    io_write(8'h10, 8'h00);
    check({7'b0, net_reset_n}, 8'h01, "R7 reset released");
    io_write(8'h11, 8'h01);
    check({7'b0, net_analyse_n}, 8'h00, "R7 analyse asserted");
    io_write(8'h11, 8'h00);
    check({7'b0, net_analyse_n}, 8'h01, "R7 analyse released");
    io_write(8'h12, 8'hFF);
    check({6'b0, net_reset_n, net_analyse_n}, 8'h03, "R1 unmapped write");

    // R2 input side
    @(negedge clk); lk_in_data = 8'hA5; lk_in_valid = 1'b1;
    @(negedge clk); lk_in_data = 8'h3C;
    check({7'b0, lk_in_ready}, 8'h00, "R2 ready low when held");
    repeat (2) @(negedge clk);
    io_write(8'h00, 8'h77);  // R9 write to input data ignored
    io_read(8'h02, rv); check(rv, 8'h01, "R4 in flag");
    io_write(8'h02, 8'h02);
    check({7'b0, irq}, 8'h01, "R5 irq input");
    io_read(8'h00, rv); check(rv, 8'hA5, "R2 first byte kept");
    @(negedge clk); lk_in_valid = 1'b0;
    io_read(8'h00, rv); check(rv, 8'h3C, "R2 second byte after read");
    check({7'b0, irq}, 8'h00, "R5 irq drops when emptied");
    io_write(8'h02, 8'h00);

    // R3 output side
    io_write(8'h01, 8'h5A);
    check({7'b0, lk_out_valid}, 8'h01, "R3 valid");
    check(lk_out_data, 8'h5A, "R3 data");
    io_read(8'h03, rv); check(rv, 8'h00, "R3 flag cleared");
    io_write(8'h01, 8'h11);
    check(lk_out_data, 8'h5A, "R3 busy write ignored");
    io_write(8'h03, 8'h02);
    check({7'b0, irq}, 8'h00, "R5 no irq while busy");
    @(negedge clk); lk_out_ready = 1'b1;
    @(negedge clk); lk_out_ready = 1'b0;
    check({7'b0, lk_out_valid}, 8'h00, "R3 released");
    check({7'b0, irq}, 8'h01, "R5 irq output");
    io_read(8'h03, rv); check(rv, 8'h03, "R3 flag back");
    io_write(8'h03, 8'h00);

    // R6 error synchronizer
    @(negedge clk); err_n = 5'b11101;
    @(negedge clk); io_addr = BASE + 10'h10; io_rd = 1'b1;
    #1 check(io_rdata, 8'h00, "R6 after one edge");
    @(negedge clk);
    #1 check(io_rdata, 8'h01, "R6 after two edges");
    io_rd = 1'b0;
    err_n = '1;
    repeat (3) @(negedge clk);
    io_read(8'h10, rv); check(rv, 8'h00, "R6 cleared");

    finish_run();
  end
endmodule